// File: doc/BRIEF.md
# Bidirectional Parallel Port with Edge-Triggered Input Capture

This block is an 8-bit bidirectional port that sits on a small microprocessor register bus. Each pin has its own direction bit. A pin whose bit is set is driven from an output register. A pin whose bit is clear is left floating so that outside logic can drive it. A read of the data register returns one of two values: the live level on the pins, or a snapshot of the pins taken at the last active transition of a control input line. The active transition is rising or falling, chosen by software.

A flag records that an active transition has occurred. A second control line, driven by the block, acts as a handshake strobe towards the peripheral. Any access to the data register pulls the strobe low. In handshake mode it stays low until the next active transition on the input line. In pulse mode it stays low for a single clock.

The register bus is plain, not valid/ready. A write takes effect on the clock edge where `cs` and `we` are both high. Reads are combinational and never stall, so the bus has no back-pressure. Register offsets: 0 is the control register, 1 is the data register, 2 is a reserved slot, and 3 is the direction register.

Top module: `vp_port`

## Requirements
- R1: After reset, `pin_oe` and `pin_out` are 0, the control register reads 0x00, and `strobe_out` is high.
- R2: A write to offset 3 loads the direction register, and `pin_oe` equals the written value from the next clock. A read of offset 3 returns the stored value.
- R3: A write to offset 1 loads the output register, and `pin_out` equals the written value from the next clock. Bits whose direction bit is 0 keep the stored value but leave `pin_oe` low. They become driven, with that stored value, once the direction register sets them.
- R4: With control bit 0 (capture enable) clear, a read of offset 1 returns the current `pin_in` combinationally, whatever the direction bits are.
- R5: With capture enable set, a read of offset 1 returns the `pin_in` value held at the clock edge where an active transition of `ctl_in` is recognised. `ctl_in` passes through two synchronizer flops, so that edge is the third rising clock edge after `ctl_in` changes.
- R6: Control bit 1 selects the active transition: 1 means rising and 0 means falling. A transition of the other polarity neither updates the snapshot nor sets the flag.
- R7: Control register bit 7 is a read-only flag. It is set by an active transition and cleared by any access (read or write) to offset 1. If both happen on the same edge, the set wins. Writes to bit 7 are ignored.
- R8: With control bit 2 clear (handshake mode), `strobe_out` goes low on the edge of an offset 1 access. It returns high on the edge where the next active transition is recognised.
- R9: With control bit 2 set (pulse mode), an offset 1 access drives `strobe_out` low for exactly one clock.
- R10: Offset 2 reads as 0x00, and writes to it change no state or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Register access select |
| we | input | 1 | 1 = write, 0 = read (when `cs` is high) |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| pin_in | input | 8 | Levels sampled from the port pins |
| pin_out | output | 8 | Output register value toward the pins |
| pin_oe | output | 8 | Per-pin output enable (1 = drive) |
| ctl_in | input | 1 | Asynchronous capture/handshake input line |
| strobe_out | output | 1 | Handshake/pulse strobe toward the peripheral |

## Verification
Register writes show up on `pin_oe`, `pin_out` and readback one clock after the write edge. The bench applies each access at a falling edge and samples at the next falling edge. Read data is combinational, so it is sampled a fraction of a cycle after the address is applied and before the access edge. Effects of `ctl_in` (snapshot, flag, strobe release) are due on the third rising edge after the line changes. The bench looks before that edge to confirm nothing has changed yet, then looks after it. It also places a data access exactly on that third edge to check the flag's set-over-clear priority. Pulse-mode strobe width is checked at the two falling edges that follow the access.

// File: rtl/vp_pkg.sv
package vp_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_RSVD = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 2'd3;

  localparam int CB_CAPEN = 0;
  localparam int CB_RISE  = 1;
  localparam int CB_PULSE = 2;
  localparam int CB_FLAG  = 7;

  typedef struct packed {
    logic pulse;
    logic rise;
    logic cap_en;
  } ctrl_t;
endpackage

// File: rtl/vp_edge.sv
module vp_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic rise_sel,
  output logic hit
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= line_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], line_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[TOP];
  end

  always_comb begin
    if (rise_sel) hit = sync_q[TOP] & ~prev_q;
    else          hit = ~sync_q[TOP] & prev_q;
  end
endmodule

// File: rtl/vp_regs.sv
module vp_regs
  import vp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      out_q,
  output ctrl_t             ctrl_q,
  output logic              data_acc
);
  logic wr;
  assign wr       = cs & we;
  assign data_acc = cs & (addr == OFS_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      ctrl_q <= '0;
    end else if (wr) begin
      unique case (addr)
        OFS_DIR:  dir_q <= wdata;
        OFS_DATA: out_q <= wdata;
        OFS_CTRL: begin
          ctrl_q.cap_en <= wdata[CB_CAPEN];
          ctrl_q.rise   <= wdata[CB_RISE];
          ctrl_q.pulse  <= wdata[CB_PULSE];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vp_capture.sv
module vp_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  input  logic         data_acc,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] snap_q,
  output logic         flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (hit)           snap_q <= pin_in;
      if (hit)           flag_q <= 1'b1;
      else if (data_acc) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vp_strobe.sv
module vp_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic data_acc,
  input  logic pulse,
  output logic strobe_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        strobe_q <= 1'b1;
    else if (data_acc) strobe_q <= 1'b0;
    else if (pulse)    strobe_q <= 1'b1;
    else if (hit)      strobe_q <= 1'b1;
  end
endmodule

// File: rtl/vp_port.sv
module vp_port
  import vp_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  input  logic              ctl_in,
  output logic              strobe_out
);
  logic [W-1:0] dir_q, out_q, snap_q;
  ctrl_t        ctrl_q;
  logic         data_acc, hit, flag_q;
  logic [W-1:0] ctrl_rd;

  vp_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .dir_q(dir_q), .out_q(out_q), .ctrl_q(ctrl_q), .data_acc(data_acc)
  );

  vp_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .line_in(ctl_in), .rise_sel(ctrl_q.rise), .hit(hit)
  );

  vp_capture #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_n), .hit(hit), .data_acc(data_acc),
    .pin_in(pin_in), .snap_q(snap_q), .flag_q(flag_q)
  );

  vp_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .hit(hit), .data_acc(data_acc),
    .pulse(ctrl_q.pulse), .strobe_q(strobe_out)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[CB_CAPEN] = ctrl_q.cap_en;
    ctrl_rd[CB_RISE]  = ctrl_q.rise;
    ctrl_rd[CB_PULSE] = ctrl_q.pulse;
    ctrl_rd[CB_FLAG]  = flag_q;
  end

  always_comb begin
    unique case (addr)
      OFS_CTRL: rdata = ctrl_rd;
      OFS_DATA: rdata = ctrl_q.cap_en ? snap_q : pin_in;
      OFS_DIR:  rdata = dir_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/vp_port_chk.sv
module vp_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs,
  input logic         we,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe,
  input logic         strobe_out,
  input logic         hit,
  input logic         flag_q,
  input logic         pulse_mode
);
  // R2
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && addr == 2'd3) |=> pin_oe == $past(wdata));

  // R3
  out_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && addr == 2'd1) |=> pin_out == $past(wdata));

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && addr == 2'd1 && !hit) |=> !flag_q);

  // R8
  strobe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && addr == 2'd1) |=> !strobe_out);

  // R9
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && !strobe_out && !(cs && addr == 2'd1)) |=> strobe_out);

  // R10
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && addr == 2'd2) |=> ($stable(pin_oe) && $stable(pin_out)));
endmodule

bind vp_port vp_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .strobe_out(strobe_out),
  .hit(hit), .flag_q(flag_q), .pulse_mode(ctrl_q.pulse)
);

// File: tb/tb_vp_port.sv
`timescale 1ns/1ps
module tb_vp_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, pin_in = '0;
  logic [7:0] rdata, pin_out, pin_oe;
  logic       ctl_in = 1'b0;
  logic       strobe_out;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vp_port dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .ctl_in(ctl_in), .strobe_out(strobe_out)
  );

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  // sample combinational data before the access edge, release after it
  task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
    cs = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    @(negedge clk);
    check("R1 oe", pin_oe, 8'h00);
    check("R1 out", pin_out, 8'h00);
    check("R1 strobe", {7'd0, strobe_out}, 8'h01);
    bus_rd(2'd0, v);
    check("R1 ctrl", v, 8'h00);
  endtask

  task automatic t_direction();
    logic [7:0] v;
    bus_wr(2'd3, 8'hA5);
    check("R2 oe", pin_oe, 8'hA5);
    bus_rd(2'd3, v);
    check("R2 readback", v, 8'hA5);
  endtask

  task automatic t_output_hold();
    bus_wr(2'd3, 8'h00);
    bus_wr(2'd1, 8'h3C);
    check("R3 out stored", pin_out, 8'h3C);
    check("R3 undriven", pin_oe, 8'h00);
    bus_wr(2'd3, 8'hFF);
    check("R3 now driven", pin_oe, 8'hFF);
    check("R3 value kept", pin_out, 8'h3C);
  endtask

  task automatic t_live_read();
    logic [7:0] v;
    bus_wr(2'd0, 8'h00);
    pin_in = 8'h5A;
    bus_rd(2'd1, v);
    check("R4 live 5A", v, 8'h5A);
    pin_in = 8'hC3;
    bus_rd(2'd1, v);
    check("R4 live C3", v, 8'hC3);
  endtask

  task automatic t_capture();
    logic [7:0] v;
    bus_wr(2'd0, 8'h03);
    pin_in = 8'h81;
    ctl_in = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_rd(2'd0, v);
    check("R5 no flag before third edge", v & 8'h80, 8'h00);
    bus_rd(2'd0, v);
    check("R7 flag set", v & 8'h80, 8'h80);
    pin_in = 8'h18;
    bus_rd(2'd1, v);
    check("R5 snapshot", v, 8'h81);
    bus_rd(2'd0, v);
    check("R7 flag cleared by read", v & 8'h80, 8'h00);
    ctl_in = 1'b0;
    repeat (4) @(negedge clk);
    bus_rd(2'd0, v);
    check("R6 falling ignored flag", v & 8'h80, 8'h00);
    bus_rd(2'd1, v);
    check("R6 falling ignored snap", v, 8'h81);
    bus_wr(2'd0, 8'h01);
    pin_in = 8'h42;
    ctl_in = 1'b1;
    repeat (4) @(negedge clk);
    bus_rd(2'd0, v);
    check("R6 rising ignored in falling mode", v & 8'h80, 8'h00);
    ctl_in = 1'b0;
    repeat (4) @(negedge clk);
    bus_rd(2'd0, v);
    check("R6 falling flag", v & 8'h80, 8'h80);
    bus_rd(2'd1, v);
    check("R6 falling snap", v, 8'h42);
  endtask

  task automatic t_flag_priority();
    logic [7:0] v;
    bus_wr(2'd0, 8'h03);
    ctl_in = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_rd(2'd1, v);
    bus_rd(2'd0, v);
    check("R7 set wins over access", v & 8'h80, 8'h80);
    bus_rd(2'd1, v);
    bus_wr(2'd0, 8'h83);
    bus_rd(2'd0, v);
    check("R7 bit7 write ignored", v, 8'h03);
  endtask

  task automatic t_handshake();
    logic [7:0] v;
    bus_rd(2'd1, v);
    check("R8 strobe low", {7'd0, strobe_out}, 8'h00);
    repeat (5) @(negedge clk);
    check("R8 strobe held", {7'd0, strobe_out}, 8'h00);
    ctl_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 wrong edge keeps low", {7'd0, strobe_out}, 8'h00);
    ctl_in = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R8 before third edge", {7'd0, strobe_out}, 8'h00);
    @(negedge clk);
    check("R8 released", {7'd0, strobe_out}, 8'h01);
  endtask

  task automatic t_pulse();
    bus_wr(2'd0, 8'h07);
    bus_wr(2'd1, 8'h99);
    check("R9 low one clock", {7'd0, strobe_out}, 8'h00);
    @(negedge clk);
    check("R9 back high", {7'd0, strobe_out}, 8'h01);
    @(negedge clk);
    check("R9 stays high", {7'd0, strobe_out}, 8'h01);
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    bus_wr(2'd2, 8'hFF);
    bus_rd(2'd2, v);
    check("R10 reads zero", v, 8'h00);
    check("R10 out kept", pin_out, 8'h99);
    bus_rd(2'd3, v);
    check("R10 dir kept", v, 8'hFF);
    bus_rd(2'd0, v);
    check("R10 ctrl kept", v & 8'h07, 8'h07);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direction();
    t_output_hold();
    t_live_read();
    t_capture();
    t_flag_priority();
    t_handshake();
    t_pulse();
    t_reserved();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule